// File: doc/BRIEF.md
# Multiplexed Bus Demultiplexer and Strobe Decoder

This block sits next to an 8-bit processor whose low address byte and data byte share one set of pins. While the address-latch-enable strobe is high, the shared bus carries the low address byte. The block passes that byte through a level-transparent latch. When the strobe falls, the latch keeps the byte for the rest of the machine cycle, so the low address stays valid after the pins switch over to data. The latched byte is joined with the high address byte, which comes straight from the processor, to form a 16-bit address.

The block also splits the processor's shared active-low read and write strobes into four active-low strobes: memory read, memory write, I/O read and I/O write. The split depends on the IO/memory select, which is low for memory and high for I/O. A data transceiver connects the processor's shared bus to the system data bus. Its direction follows the read strobe, and its active-low enable is open only during a data phase with exactly one strobe asserted. Tri-state pins are modelled as separate input, output and output-enable ports. If read and write are ever both asserted, the transceiver is shut on both sides and an error output is raised. The processor is assumed to run with no wait states.

Top module: `mbus_demux`

## Requirements
- R1: While `ale` is high and `rst_n` is high, `addr[7:0]` equals `ad_in`.
- R2: While `ale` is low, `addr[7:0]` keeps the value it had when `ale` fell, whatever `ad_in` does.
- R3: `addr[15:8]` always equals `a_hi`.
- R4: `mem_rd_n` is low only when both `rd_n` and `io_m` are low. `mem_wr_n` is low only when both `wr_n` and `io_m` are low.
- R5: `io_rd_n` is low only when `rd_n` is low and `io_m` is high. `io_wr_n` is low only when `wr_n` is low and `io_m` is high.
- R6: `xcvr_dir` equals `rd_n`: 1 means processor toward system (write), 0 means system toward processor (read).
- R7: `xcvr_en_n` is low only when `ale` is low and exactly one of `rd_n` and `wr_n` is low.
- R8: When the transceiver is enabled for a write, `dbus_oe` is 1 and `dbus_out` equals `ad_in`. When it is enabled for a read, `ad_oe` is 1 and `ad_out` equals `dbus_in`. When it is disabled, both output enables are 0.
- R9: When `rd_n` and `wr_n` are both low, `strobe_conflict` is 1 and neither `ad_oe` nor `dbus_oe` is 1. Otherwise `strobe_conflict` is 0.
- R10: While `rst_n` is low, `addr[7:0]` is 0.
- R11: `ad_oe` and `dbus_oe` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock used by the reset and the checker |
| rst_n | input | 1 | Active-low reset; clears the address latch |
| ale | input | 1 | Address latch enable from the processor |
| io_m | input | 1 | Cycle select: 0 for memory, 1 for I/O |
| rd_n | input | 1 | Processor read strobe, active low |
| wr_n | input | 1 | Processor write strobe, active low |
| a_hi | input | 8 | High address byte from the processor |
| ad_in | input | 8 | Shared address/data pins, value seen from the processor |
| ad_out | output | 8 | Data driven back onto the shared pins |
| ad_oe | output | 1 | Output enable for `ad_out` |
| addr | output | 16 | Demultiplexed 16-bit address |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | I/O read strobe, active low |
| io_wr_n | output | 1 | I/O write strobe, active low |
| xcvr_dir | output | 1 | Transceiver direction (1 = outward) |
| xcvr_en_n | output | 1 | Transceiver enable, active low |
| dbus_in | input | 8 | System data bus, value from memory or I/O |
| dbus_out | output | 8 | Data driven onto the system data bus |
| dbus_oe | output | 1 | Output enable for `dbus_out` |
| strobe_conflict | output | 1 | Read and write strobes asserted together |

## Verification
The hardest case to reach is the hold: the low address must survive after `ale` falls, while the shared pins carry unrelated data and the strobes toggle. The bench runs every machine cycle as three phases. In T1 the address byte is driven with `ale` high. In T2 and T3 `ad_in` is replaced by a data byte, and an unrelated data byte is driven on `dbus_in`. This is done for all four cycle types and a spread of addresses. The decode and the conflict path are then swept over all combinations of `io_m`, `rd_n`, `wr_n` and `ale`.

// File: rtl/mbus_demux_pkg.sv
// Package: shared widths and the cycle-kind encoding for the bus demultiplexer.
// Assumes an 8-bit multiplexed low byte and an 8-bit dedicated high byte.
package mbus_demux_pkg;
    localparam int unsigned LO_W   = 8;
    localparam int unsigned HI_W   = 8;
    localparam int unsigned ADDR_W = LO_W + HI_W;

    // Kind of data phase currently requested by the strobes
    typedef enum logic [1:0] {
        XFER_IDLE  = 2'b00,
        XFER_READ  = 2'b01,
        XFER_WRITE = 2'b10,
        XFER_CLASH = 2'b11
    } xfer_e;

    // Classify the strobe pair into a transfer kind
    function automatic xfer_e classify(input logic rd_n, input logic wr_n);
        return xfer_e'({~wr_n, ~rd_n});
    endfunction
endpackage

// File: rtl/mbus_addr_latch.sv
// Module: mbus_addr_latch
// Level-transparent latch for the low address byte. Transparent while the
// enable is high, holding while it is low. Reset (active low) forces zero.
// Assumes the enable is high only while the shared bus carries the address.
module mbus_addr_latch #(
    parameter int unsigned W = 8
) (
    input  logic         rst_n,
    input  logic         le,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture the bus while enabled, hold otherwise
    always_latch begin
        if (!rst_n) begin
            q = '0;
        end else if (le) begin
            q = d;
        end
    end
endmodule

// File: rtl/mbus_strobe_decode.sv
// Module: mbus_strobe_decode
// Splits the shared active-low read/write strobes into memory and I/O
// strobes by OR-ing with the select (memory) or its inverse (I/O).
// Assumes io_m is 0 for memory and 1 for I/O.
module mbus_strobe_decode (
    input  logic io_m,
    input  logic rd_n,
    input  logic wr_n,
    output logic mem_rd_n,
    output logic mem_wr_n,
    output logic io_rd_n,
    output logic io_wr_n
);
    localparam int unsigned NSTB = 4;
    logic [NSTB-1:0] base_n;
    logic [NSTB-1:0] sel_n;
    logic [NSTB-1:0] out_n;

    // Strobe sources and qualifiers, index order: mrd, mwr, iord, iowr
    always_comb begin
        base_n = {wr_n, rd_n, wr_n, rd_n};
        sel_n  = {~io_m, ~io_m, io_m, io_m};
    end

    for (genvar i = 0; i < NSTB; i++) begin : g_or
        assign out_n[i] = base_n[i] | sel_n[i];
    end

    assign mem_rd_n = out_n[0];
    assign mem_wr_n = out_n[1];
    assign io_rd_n  = out_n[2];
    assign io_wr_n  = out_n[3];
endmodule

// File: rtl/mbus_xcvr_ctrl.sv
// Module: mbus_xcvr_ctrl
// Controls the bidirectional transceiver between the shared bus (side A)
// and the system data bus (side B). Direction follows rd_n. The enable is
// open only in a data phase with exactly one strobe asserted. A strobe
// clash closes both sides and raises a flag.
module mbus_xcvr_ctrl
    import mbus_demux_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         ale,
    input  logic         rd_n,
    input  logic         wr_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b_out,
    output logic         b_oe,
    output logic         dir,
    output logic         en_n,
    output logic         clash
);
    xfer_e kind;

    // Work out the transfer kind and the enable
    always_comb begin
        kind  = classify(rd_n, wr_n);
        clash = (kind == XFER_CLASH);
        dir   = rd_n;
        en_n  = ale | (kind == XFER_IDLE) | clash;
    end

    // Gate each side's output enable by enable and direction
    always_comb begin
        a_oe  = ~en_n & ~dir;
        b_oe  = ~en_n &  dir;
        a_out = b_in;
        b_out = a_in;
    end
endmodule

// File: rtl/mbus_demux.sv
// Module: mbus_demux (top)
// Demultiplexes the processor's shared low address/data bus, forms the
// 16-bit address, decodes the four memory and I/O strobes, and steers the
// data transceiver. Assumes no wait states (ready held high).
module mbus_demux
    import mbus_demux_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale,
    input  logic              io_m,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [HI_W-1:0]   a_hi,
    input  logic [LO_W-1:0]   ad_in,
    output logic [LO_W-1:0]   ad_out,
    output logic              ad_oe,
    output logic [ADDR_W-1:0] addr,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic              io_rd_n,
    output logic              io_wr_n,
    output logic              xcvr_dir,
    output logic              xcvr_en_n,
    input  logic [LO_W-1:0]   dbus_in,
    output logic [LO_W-1:0]   dbus_out,
    output logic              dbus_oe,
    output logic              strobe_conflict
);
    logic [LO_W-1:0] lo_q;
    logic            clk_unused;

    // clk is used only by the bound checker
    assign clk_unused = clk;

    mbus_addr_latch #(.W(LO_W)) u_latch (
        .rst_n (rst_n),
        .le    (ale),
        .d     (ad_in),
        .q     (lo_q)
    );

    // Join the dedicated high byte with the held low byte
    assign addr = {a_hi, lo_q};

    mbus_strobe_decode u_dec (
        .io_m     (io_m),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .mem_rd_n (mem_rd_n),
        .mem_wr_n (mem_wr_n),
        .io_rd_n  (io_rd_n),
        .io_wr_n  (io_wr_n)
    );

    mbus_xcvr_ctrl #(.W(LO_W)) u_xcvr (
        .ale   (ale),
        .rd_n  (rd_n),
        .wr_n  (wr_n),
        .a_in  (ad_in),
        .b_in  (dbus_in),
        .a_out (ad_out),
        .a_oe  (ad_oe),
        .b_out (dbus_out),
        .b_oe  (dbus_oe),
        .dir   (xcvr_dir),
        .en_n  (xcvr_en_n),
        .clash (strobe_conflict)
    );
endmodule

// File: rtl/mbus_demux_chk.sv
// Module: mbus_demux_chk
// Checker bound to mbus_demux. It samples ports on the rising clock edge.
// Assumes the inputs are stable at the edge.
module mbus_demux_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ale,
    input logic        io_m,
    input logic        rd_n,
    input logic        wr_n,
    input logic [7:0]  a_hi,
    input logic [7:0]  ad_in,
    input logic [15:0] addr,
    input logic        mem_rd_n,
    input logic        mem_wr_n,
    input logic        io_rd_n,
    input logic        io_wr_n,
    input logic        xcvr_dir,
    input logic        xcvr_en_n,
    input logic        ad_oe,
    input logic        dbus_oe,
    input logic        strobe_conflict
);
    // R1
    transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> addr[7:0] == ad_in);
    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ale && $past(rst_n) && !$past(ale)) |-> $stable(addr[7:0]));
    // R3
    high_byte_chk: assert property (@(posedge clk) addr[15:8] == a_hi);
    // R4
    mem_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_n |-> (!rd_n && !io_m)) and (!mem_wr_n |-> (!wr_n && !io_m)));
    // R5
    io_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_rd_n |-> (!rd_n && io_m)) and (!io_wr_n |-> (!wr_n && io_m)));
    // R6
    dir_chk: assert property (@(posedge clk) xcvr_dir == rd_n);
    // R7
    enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xcvr_en_n |-> (!ale && (rd_n != wr_n)));
    // R9
    conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_conflict |-> (!ad_oe && !dbus_oe));
    // R10
    reset_clear_chk: assert property (@(posedge clk)
        (!rst_n && !$isunknown(rst_n) && $past(!rst_n)) |-> addr[7:0] == 8'h00);
    // R11
    one_side_chk: assert property (@(posedge clk) !(ad_oe && dbus_oe));
    // R4 R5
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~mem_rd_n, ~mem_wr_n, ~io_rd_n, ~io_wr_n}) <= 2);
endmodule

bind mbus_demux mbus_demux_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .ale             (ale),
    .io_m            (io_m),
    .rd_n            (rd_n),
    .wr_n            (wr_n),
    .a_hi            (a_hi),
    .ad_in           (ad_in),
    .addr            (addr),
    .mem_rd_n        (mem_rd_n),
    .mem_wr_n        (mem_wr_n),
    .io_rd_n         (io_rd_n),
    .io_wr_n         (io_wr_n),
    .xcvr_dir        (xcvr_dir),
    .xcvr_en_n       (xcvr_en_n),
    .ad_oe           (ad_oe),
    .dbus_oe         (dbus_oe),
    .strobe_conflict (strobe_conflict)
);

// File: tb/mbus_demux_bench.sv
module mbus_demux_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ale = 1'b0, io_m = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0]  a_hi = 8'h00, ad_in = 8'h00, dbus_in = 8'h00;
    logic [7:0]  ad_out, dbus_out;
    logic        ad_oe, dbus_oe;
    logic [15:0] addr;
    logic        mem_rd_n, mem_wr_n, io_rd_n, io_wr_n;
    logic        xcvr_dir, xcvr_en_n, strobe_conflict;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    mbus_demux u_mbus_demux (
        .clk(clk), .rst_n(rst_n), .ale(ale), .io_m(io_m), .rd_n(rd_n), .wr_n(wr_n),
        .a_hi(a_hi), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .addr(addr),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
        .xcvr_dir(xcvr_dir), .xcvr_en_n(xcvr_en_n), .dbus_in(dbus_in),
        .dbus_out(dbus_out), .dbus_oe(dbus_oe), .strobe_conflict(strobe_conflict)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive at the falling edge, sample 1 ns later
    task automatic step();
        @(negedge clk);
    endtask

    // Full comparison of decode and transceiver outputs against computed values
    task automatic check_comb();
        logic en, wr_dir;
        en     = !ale && (rd_n != wr_n);
        wr_dir = rd_n;
        chk("R3", {8'h00, addr[15:8]}, {8'h00, a_hi});
        chk("R4", {14'h0, mem_rd_n, mem_wr_n}, {14'h0, rd_n | io_m, wr_n | io_m});
        chk("R5", {14'h0, io_rd_n, io_wr_n}, {14'h0, rd_n | ~io_m, wr_n | ~io_m});
        chk("R6", {15'h0, xcvr_dir}, {15'h0, rd_n});
        chk("R7", {15'h0, xcvr_en_n}, {15'h0, ~en});
        chk("R8", {14'h0, ad_oe, dbus_oe}, {14'h0, en & ~wr_dir, en & wr_dir});
        if (en && wr_dir)  chk("R8", {8'h00, dbus_out}, {8'h00, ad_in});
        if (en && !wr_dir) chk("R8", {8'h00, ad_out}, {8'h00, dbus_in});
        chk("R9", {15'h0, strobe_conflict}, {15'h0, (!rd_n && !wr_n)});
        chk("R11", {15'h0, ad_oe & dbus_oe}, 16'h0);
    endtask

    // One machine cycle: T1 address, T2/T3 data with strobe asserted
    task automatic run_cycle(input logic iom, input logic is_rd, input logic [15:0] a,
                             input logic [7:0] dat);
        step(); io_m = iom; a_hi = a[15:8]; ad_in = a[7:0]; ale = 1'b1;
        rd_n = 1'b1; wr_n = 1'b1;
        #1; chk("R1", addr, a); check_comb();
        step(); ale = 1'b0; ad_in = dat; dbus_in = ~dat;
        rd_n = ~is_rd; wr_n = is_rd;
        #1; chk("R2", addr, a); check_comb();
        step(); ad_in = dat ^ 8'h5A; dbus_in = dat + 8'd3;
        #1; chk("R2", addr, a); check_comb();
        // exactly one decoded strobe in the data phase (R4, R5)
        chk("R4", 16'($countones({~mem_rd_n, ~mem_wr_n, ~io_rd_n, ~io_wr_n})), 16'd1);
        step(); rd_n = 1'b1; wr_n = 1'b1; ad_in = 8'hFF;
        #1; chk("R2", addr, a); check_comb();
    endtask

    initial begin
        // Reset state (R10)
        a_hi = 8'h12; ad_in = 8'hC3; ale = 1'b1;
        repeat (3) step();
        #1; chk("R10", {8'h00, addr[7:0]}, 16'h0000);
        check_comb();
        step(); ale = 1'b0; rst_n = 1'b1;
        #1; chk("R10", {8'h00, addr[7:0]}, 16'h0000);
        // Machine cycles of all four kinds over a spread of addresses
        for (int k = 0; k < 4; k++) begin
            for (int n = 0; n < 24; n++) begin
                logic [15:0] a;
                a = 16'(n * 16'h0B3D + k * 16'h1111 + 16'h0081);
                run_cycle(k[1], k[0], a, 8'(n * 37 + k));
            end
        end
        // Exhaustive strobe sweep, including the clash (R9)
        for (int v = 0; v < 16; v++) begin
            step(); ale = v[3]; io_m = v[2]; rd_n = v[1]; wr_n = v[0];
            ad_in = 8'(v * 17); dbus_in = 8'(~v * 9);
            #1; check_comb();
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule